// File: doc/BRIEF.md
# Multithreaded Reorder Buffer Commit Tracker

This block tracks in-flight instructions for several hardware threads that share one reorder buffer. Each thread has its own in-order circular queue. All the queues draw on a common pool of entries. An entry holds a sequence number, a PC, a ready-to-commit flag and a squashed flag. Dispatch appends an entry to the tail of a chosen thread's queue and receives a tag back. The tag is made of the thread number and the slot index. Execution later marks that entry as complete through the tag, and can also flag it as squashed. Commit then retires the head of a named thread, but only once that head is ready.

For every thread the block presents the head entry and whether it is ready. An empty thread shows a cleared head instead of stale contents. Across the threads that are currently enabled, the block also derives three results: the globally oldest head (lowest sequence number), the globally youngest tail (highest sequence number), and a single flag that says whether any commit is possible this cycle. The commit stage uses these to choose which thread to retire from, and the recovery logic uses them to learn the age span of the buffer.

Top module: `mt_rob_tracker`

## Requirements
- R1: After reset every queue is empty, the total count is 0, the oldest and youngest outputs are invalid, and the commit-possible flag is 0.
- R2: An accepted insert appends to the tail of its own thread and raises both that thread's occupancy and the total count by one. The returned tag is {thread id in bits 3:2, slot index in bits 1:0}. Each thread hands out slots in circular order 0,1,2,3,0,…, starting from slot 0 after reset.
- R3: An insert is ignored when its thread already holds 4 entries or when the total count equals the shared capacity of 8. An ignored insert reports acceptance 0 and changes no state.
- R4: Completion addressed by tag sets the ready flag of that slot. When the squash input is also set, it sets the slot's squashed flag as well. A squashed flag stays set until the slot is reused.
- R5: A retire removes the head of the named thread only if that head is ready. It then lowers the thread occupancy and the total count by one. A retire aimed at a head that is not ready, or at an empty thread, has no effect.
- R6: A thread whose queue is empty shows head valid 0, and its head sequence number, PC, ready flag and squashed flag all read 0.
- R7: The oldest output selects the lowest head sequence number among the threads that are both enabled and non-empty, with the lower thread id winning a tie. It is invalid when no such thread exists.
- R8: The youngest output selects the highest tail sequence number among the threads that are both enabled and non-empty. It is invalid when no such thread exists.
- R9: The commit-possible flag is 1 exactly when some enabled thread has a ready head. A ready head in a disabled thread does not raise it.
- R10: An insert and a retire on the same thread in the same cycle both take effect, and the thread's slot pointers wrap around past slot 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_mask_i | input | 4 | Enabled threads, one bit per thread |
| ins_vld_i | input | 1 | Insert request |
| ins_tid_i | input | 2 | Thread of the insert |
| ins_seq_i | input | 16 | Sequence number of the inserted instruction |
| ins_pc_i | input | 32 | PC of the inserted instruction |
| ins_tag_o | output | 4 | Tag that the insert receives ({thread, slot}) |
| ins_take_o | output | 1 | Insert is accepted this cycle |
| done_vld_i | input | 1 | Completion request |
| done_tag_i | input | 4 | Tag of the completed entry |
| done_sq_i | input | 1 | Also mark the completed entry as squashed |
| ret_vld_i | input | 1 | Retire request |
| ret_tid_i | input | 2 | Thread whose head is retired |
| thr_hd_vld_o | output | 4 | Per-thread head present |
| thr_hd_seq_o | output | 64 | Per-thread head sequence number, thread t at bits 16t+15:16t |
| thr_hd_pc_o | output | 128 | Per-thread head PC, thread t at bits 32t+31:32t |
| thr_hd_rdy_o | output | 4 | Per-thread head ready to commit |
| thr_hd_sq_o | output | 4 | Per-thread head squashed |
| commit_ok_o | output | 1 | Some enabled thread has a ready head |
| total_o | output | 4 | Entries held across all threads |
| old_vld_o | output | 1 | Oldest head valid |
| old_tid_o | output | 2 | Thread holding the oldest head |
| old_seq_o | output | 16 | Sequence number of the oldest head |
| young_vld_o | output | 1 | Youngest tail valid |
| young_tid_o | output | 2 | Thread holding the youngest tail |
| young_seq_o | output | 16 | Sequence number of the youngest tail |

## Verification
Insert acceptance and the returned tag are combinational from the current state and the request, so they are due in the same cycle, before the capturing edge. The bench samples them 1 ns after it drives the request. Every other result (per-thread heads, oldest and youngest selections, commit-possible and the total) comes straight from registers and is due in the cycle after the edge that captures the stimulus. The driver computes those expected values just after that edge and queues them. The monitor compares them 3 ns after the same edge, well clear of the next drive at the falling edge.

// File: rtl/mt_rob_pkg.sv
package mt_rob_pkg;

  // Status bits held beside every buffered instruction.
  typedef struct packed {
    logic ready;
    logic squashed;
  } rob_flags_t;

endpackage

// File: rtl/mt_rob_queue.sv
module mt_rob_queue
  import mt_rob_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [SEQ_W-1:0] push_seq_i,
  input  logic [PC_W-1:0]  push_pc_i,
  input  logic             mark_i,
  input  logic [IDX_W-1:0] mark_idx_i,
  input  logic             mark_sq_i,
  input  logic             pop_i,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             full_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hd_vld_o,
  output logic [SEQ_W-1:0] hd_seq_o,
  output logic [PC_W-1:0]  hd_pc_o,
  output logic             hd_rdy_o,
  output logic             hd_sq_o,
  output logic [SEQ_W-1:0] tl_seq_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [IDX_W-1:0] rp_q, rp_d, wp_q, wp_d, tl_idx;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SEQ_W-1:0] seq_mem [DEPTH];
  logic [PC_W-1:0]  pc_mem  [DEPTH];
  rob_flags_t       flg_mem [DEPTH];

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  // Next-state for pointers and occupancy.
  always_comb begin
    rp_d  = rp_q;
    wp_d  = wp_q;
    cnt_d = cnt_q;
    if (push_i) wp_d = step_idx(wp_q);
    if (pop_i)  rp_d = step_idx(rp_q);
    case ({push_i, pop_i})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q  <= '0;
      wp_q  <= '0;
      cnt_q <= '0;
    end else begin
      rp_q  <= rp_d;
      wp_q  <= wp_d;
      cnt_q <= cnt_d;
    end
  end

  // Entry storage, no reset; a push overrides a same-slot completion.
  always_ff @(posedge clk) begin
    if (mark_i) begin
      flg_mem[mark_idx_i] <= '{ready: 1'b1,
                               squashed: flg_mem[mark_idx_i].squashed | mark_sq_i};
    end
    if (push_i) begin
      seq_mem[wp_q] <= push_seq_i;
      pc_mem[wp_q]  <= push_pc_i;
      flg_mem[wp_q] <= '0;
    end
  end

  assign tl_idx   = (wp_q == '0) ? LAST_IDX : wp_q - 1'b1;
  assign wr_idx_o = wp_q;
  assign full_o   = (cnt_q == FULL_CNT);
  assign cnt_o    = cnt_q;
  assign hd_vld_o = (cnt_q != '0);
  assign hd_seq_o = hd_vld_o ? seq_mem[rp_q] : '0;
  assign hd_pc_o  = hd_vld_o ? pc_mem[rp_q]  : '0;
  assign hd_rdy_o = hd_vld_o & flg_mem[rp_q].ready;
  assign hd_sq_o  = hd_vld_o & flg_mem[rp_q].squashed;
  assign tl_seq_o = hd_vld_o ? seq_mem[tl_idx] : '0;

  // R5: the parent only pops a head that is ready.
  a_r5_pop_only_ready: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> hd_rdy_o);

  // R3: the parent never pushes into a full queue.
  a_r3_push_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (cnt_q != FULL_CNT));

endmodule

// File: rtl/mt_rob_age_pick.sv
module mt_rob_age_pick #(
  parameter int NUM         = 4,
  parameter int SEQ_W       = 16,
  parameter bit PICK_OLDEST = 1'b1,
  localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic [NUM-1:0]       cand_vld_i,
  input  logic [NUM*SEQ_W-1:0] cand_seq_i,
  output logic                 pick_vld_o,
  output logic [IDX_W-1:0]     pick_idx_o,
  output logic [SEQ_W-1:0]     pick_seq_o
);

  // Strict comparison keeps the lower index on a tie.
  if (PICK_OLDEST) begin : g_min
    always_comb begin
      pick_vld_o = 1'b0;
      pick_idx_o = '0;
      pick_seq_o = '0;
      for (int i = 0; i < NUM; i++) begin
        if (cand_vld_i[i] && (!pick_vld_o || cand_seq_i[i*SEQ_W +: SEQ_W] < pick_seq_o)) begin
          pick_vld_o = 1'b1;
          pick_idx_o = IDX_W'(i);
          pick_seq_o = cand_seq_i[i*SEQ_W +: SEQ_W];
        end
      end
    end
  end else begin : g_max
    always_comb begin
      pick_vld_o = 1'b0;
      pick_idx_o = '0;
      pick_seq_o = '0;
      for (int i = 0; i < NUM; i++) begin
        if (cand_vld_i[i] && (!pick_vld_o || cand_seq_i[i*SEQ_W +: SEQ_W] > pick_seq_o)) begin
          pick_vld_o = 1'b1;
          pick_idx_o = IDX_W'(i);
          pick_seq_o = cand_seq_i[i*SEQ_W +: SEQ_W];
        end
      end
    end
  end

endmodule

// File: rtl/mt_rob_tracker.sv
module mt_rob_tracker #(
  parameter int NTHR   = 4,
  parameter int QDEPTH = 4,
  parameter int CAP    = 8,
  parameter int SEQ_W  = 16,
  parameter int PC_W   = 32,
  localparam int TID_W  = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int IDX_W  = $clog2(QDEPTH),
  localparam int TAG_W  = TID_W + IDX_W,
  localparam int TOT_W  = $clog2(CAP + 1),
  localparam int QCNT_W = $clog2(QDEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NTHR-1:0]       act_mask_i,
  input  logic                  ins_vld_i,
  input  logic [TID_W-1:0]      ins_tid_i,
  input  logic [SEQ_W-1:0]      ins_seq_i,
  input  logic [PC_W-1:0]       ins_pc_i,
  output logic [TAG_W-1:0]      ins_tag_o,
  output logic                  ins_take_o,
  input  logic                  done_vld_i,
  input  logic [TAG_W-1:0]      done_tag_i,
  input  logic                  done_sq_i,
  input  logic                  ret_vld_i,
  input  logic [TID_W-1:0]      ret_tid_i,
  output logic [NTHR-1:0]       thr_hd_vld_o,
  output logic [NTHR*SEQ_W-1:0] thr_hd_seq_o,
  output logic [NTHR*PC_W-1:0]  thr_hd_pc_o,
  output logic [NTHR-1:0]       thr_hd_rdy_o,
  output logic [NTHR-1:0]       thr_hd_sq_o,
  output logic                  commit_ok_o,
  output logic [TOT_W-1:0]      total_o,
  output logic                  old_vld_o,
  output logic [TID_W-1:0]      old_tid_o,
  output logic [SEQ_W-1:0]      old_seq_o,
  output logic                  young_vld_o,
  output logic [TID_W-1:0]      young_tid_o,
  output logic [SEQ_W-1:0]      young_seq_o
);

  localparam logic [TOT_W-1:0] CAP_C = TOT_W'(CAP);

  logic [NTHR-1:0]       q_full, push_w, mark_w, pop_w, live_w;
  logic [IDX_W-1:0]      wr_idx [NTHR];
  logic [QCNT_W-1:0]     q_cnt  [NTHR];
  logic [NTHR*SEQ_W-1:0] tl_seq;
  logic [TOT_W-1:0]      total_q, total_d, thr_sum;
  logic                  ret_take;

  // Admission: room in the thread queue and in the shared pool.
  assign ins_take_o = ins_vld_i & ~q_full[ins_tid_i] & (total_q != CAP_C);
  assign ins_tag_o  = {ins_tid_i, wr_idx[ins_tid_i]};
  assign ret_take   = ret_vld_i & thr_hd_rdy_o[ret_tid_i];

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    assign push_w[t] = ins_take_o && (ins_tid_i == TID_W'(t));
    assign mark_w[t] = done_vld_i && (done_tag_i[TAG_W-1:IDX_W] == TID_W'(t));
    assign pop_w[t]  = ret_take && (ret_tid_i == TID_W'(t));

    mt_rob_queue #(.DEPTH(QDEPTH), .SEQ_W(SEQ_W), .PC_W(PC_W)) u_q (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (push_w[t]),
      .push_seq_i (ins_seq_i),
      .push_pc_i  (ins_pc_i),
      .mark_i     (mark_w[t]),
      .mark_idx_i (done_tag_i[IDX_W-1:0]),
      .mark_sq_i  (done_sq_i),
      .pop_i      (pop_w[t]),
      .wr_idx_o   (wr_idx[t]),
      .full_o     (q_full[t]),
      .cnt_o      (q_cnt[t]),
      .hd_vld_o   (thr_hd_vld_o[t]),
      .hd_seq_o   (thr_hd_seq_o[t*SEQ_W +: SEQ_W]),
      .hd_pc_o    (thr_hd_pc_o[t*PC_W +: PC_W]),
      .hd_rdy_o   (thr_hd_rdy_o[t]),
      .hd_sq_o    (thr_hd_sq_o[t]),
      .tl_seq_o   (tl_seq[t*SEQ_W +: SEQ_W])
    );
  end

  // Shared occupancy.
  always_comb begin
    case ({ins_take_o, ret_take})
      2'b10:   total_d = total_q + 1'b1;
      2'b01:   total_d = total_q - 1'b1;
      default: total_d = total_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) total_q <= '0;
    else        total_q <= total_d;
  end

  assign total_o     = total_q;
  assign live_w      = thr_hd_vld_o & act_mask_i;
  assign commit_ok_o = |(thr_hd_rdy_o & act_mask_i);

  mt_rob_age_pick #(.NUM(NTHR), .SEQ_W(SEQ_W), .PICK_OLDEST(1'b1)) u_oldest (
    .cand_vld_i (live_w),
    .cand_seq_i (thr_hd_seq_o),
    .pick_vld_o (old_vld_o),
    .pick_idx_o (old_tid_o),
    .pick_seq_o (old_seq_o)
  );

  mt_rob_age_pick #(.NUM(NTHR), .SEQ_W(SEQ_W), .PICK_OLDEST(1'b0)) u_youngest (
    .cand_vld_i (live_w),
    .cand_seq_i (tl_seq),
    .pick_vld_o (young_vld_o),
    .pick_idx_o (young_tid_o),
    .pick_seq_o (young_seq_o)
  );

  // ---------------- assertions ----------------
  always_comb begin
    thr_sum = '0;
    for (int t = 0; t < NTHR; t++) thr_sum = thr_sum + TOT_W'(q_cnt[t]);
  end

  a_r2_total_tracks_threads: assert property (@(posedge clk) disable iff (!rst_n)
    total_q == thr_sum);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    total_q <= CAP_C);

  a_r2_insert_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_take_o && !ret_take) |=> (total_q == $past(total_q) + 1'b1));

  a_r9_commit_needs_head: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok_o |-> old_vld_o);

  for (genvar t = 0; t < NTHR; t++) begin : g_age_chk
    a_r7_oldest_bound: assert property (@(posedge clk) disable iff (!rst_n)
      live_w[t] |-> (old_vld_o && old_seq_o <= thr_hd_seq_o[t*SEQ_W +: SEQ_W]));
    a_r8_youngest_bound: assert property (@(posedge clk) disable iff (!rst_n)
      live_w[t] |-> (young_vld_o && young_seq_o >= tl_seq[t*SEQ_W +: SEQ_W]));
  end

endmodule

// File: tb/mt_rob_tracker_tb.sv
`timescale 1ns/1ps
module mt_rob_tracker_tb;

  localparam int NT = 4;
  localparam int QD = 4;
  localparam int CAPB = 8;

  logic        clk, rst_n;
  logic [3:0]  act_mask;
  logic        ins_vld, done_vld, done_sq, ret_vld;
  logic [1:0]  ins_tid, ret_tid;
  logic [15:0] ins_seq;
  logic [31:0] ins_pc;
  logic [3:0]  ins_tag, done_tag;
  logic        ins_take;
  logic [3:0]  hd_vld, hd_rdy, hd_sq;
  logic [63:0] hd_seq;
  logic [127:0] hd_pc;
  logic        commit_ok, old_vld, young_vld;
  logic [3:0]  total;
  logic [1:0]  old_tid, young_tid;
  logic [15:0] old_seq, young_seq;

  mt_rob_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .act_mask_i(act_mask),
    .ins_vld_i(ins_vld), .ins_tid_i(ins_tid), .ins_seq_i(ins_seq), .ins_pc_i(ins_pc),
    .ins_tag_o(ins_tag), .ins_take_o(ins_take),
    .done_vld_i(done_vld), .done_tag_i(done_tag), .done_sq_i(done_sq),
    .ret_vld_i(ret_vld), .ret_tid_i(ret_tid),
    .thr_hd_vld_o(hd_vld), .thr_hd_seq_o(hd_seq), .thr_hd_pc_o(hd_pc),
    .thr_hd_rdy_o(hd_rdy), .thr_hd_sq_o(hd_sq), .commit_ok_o(commit_ok),
    .total_o(total), .old_vld_o(old_vld), .old_tid_o(old_tid), .old_seq_o(old_seq),
    .young_vld_o(young_vld), .young_tid_o(young_tid), .young_seq_o(young_seq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // Reference model
  int m_seq [NT][QD];
  int m_pc  [NT][QD];
  bit m_rdy [NT][QD];
  bit m_sq  [NT][QD];
  int m_rp [NT];
  int m_wp [NT];
  int m_cnt [NT];
  int m_tot = 0;
  bit [3:0] act = 4'hF;

  typedef struct {
    int     kind;
    int     idx;
    longint val;
    string  req;
  } exp_t;
  exp_t exp_q[$];

  function automatic void expect_val(int kind, int idx, longint val, string req);
    exp_t e;
    e.kind = kind; e.idx = idx; e.val = val; e.req = req;
    exp_q.push_back(e);
  endfunction

  function automatic longint actual(int kind, int idx);
    case (kind)
      0:  return longint'(hd_vld[idx]);
      1:  return longint'(hd_seq[idx*16 +: 16]);
      2:  return longint'(hd_pc[idx*32 +: 32]);
      3:  return longint'(hd_rdy[idx]);
      4:  return longint'(hd_sq[idx]);
      5:  return longint'(commit_ok);
      6:  return longint'(total);
      7:  return longint'(old_vld);
      8:  return longint'(old_tid);
      9:  return longint'(old_seq);
      10: return longint'(young_vld);
      11: return longint'(young_tid);
      default: return longint'(young_seq);
    endcase
  endfunction

  function automatic void check_now(longint act_v, longint exp_v, string req, string what);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act_v, exp_v);
    end
  endfunction

  // Monitor: compare queued expectations 3 ns after each rising edge.
  always @(posedge clk) begin
    #3;
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check_now(actual(e.kind, e.idx), e.val, e.req,
                $sformatf("kind %0d idx %0d", e.kind, e.idx));
    end
  end

  // Queue all output expectations from the model.
  function automatic void push_all();
    int  ot, os, yt, ys;
    bit  ov, yv, cok;
    ov = 0; yv = 0; cok = 0; ot = 0; os = 0; yt = 0; ys = 0;
    for (int t = 0; t < NT; t++) begin
      bit   e;
      int   h, tl;
      e  = (m_cnt[t] == 0);
      h  = m_rp[t];
      tl = (m_wp[t] + QD - 1) % QD;
      expect_val(0, t, e ? 0 : 1, e ? "R6" : "R2");
      expect_val(1, t, e ? 0 : m_seq[t][h], e ? "R6" : "R2");
      expect_val(2, t, e ? 0 : m_pc[t][h], e ? "R6" : "R2");
      expect_val(3, t, e ? 0 : m_rdy[t][h], e ? "R6" : "R4");
      expect_val(4, t, e ? 0 : m_sq[t][h], e ? "R6" : "R4");
      if (!e && act[t]) begin
        if (m_rdy[t][h]) cok = 1;
        if (!ov || m_seq[t][h] < os) begin ov = 1; ot = t; os = m_seq[t][h]; end
        if (!yv || m_seq[t][tl] > ys) begin yv = 1; yt = t; ys = m_seq[t][tl]; end
      end
    end
    expect_val(5, 0, cok, "R9");
    expect_val(6, 0, m_tot, "R2");
    expect_val(7, 0, ov, "R7");
    if (ov) begin expect_val(8, 0, ot, "R7"); expect_val(9, 0, os, "R7"); end
    expect_val(10, 0, yv, "R8");
    if (yv) begin expect_val(11, 0, yt, "R8"); expect_val(12, 0, ys, "R8"); end
  endfunction

  // Driver: one cycle of stimulus, model update, expectations.
  task automatic cyc(input bit iv, input int it, input int iseq, input int ipc,
                     input bit dv, input int dt, input int ds, input bit dq,
                     input bit rv, input int rt);
    bit take_i, take_r;
    @(negedge clk);
    act_mask = act;
    ins_vld = iv; ins_tid = 2'(it); ins_seq = 16'(iseq); ins_pc = 32'(ipc);
    done_vld = dv; done_tag = 4'(dt*QD + ds); done_sq = dq;
    ret_vld = rv; ret_tid = 2'(rt);
    take_i = iv && (m_cnt[it] < QD) && (m_tot < CAPB);
    take_r = rv && (m_cnt[rt] > 0) && m_rdy[rt][m_rp[rt]];
    #1;
    if (iv) begin
      check_now(longint'(ins_take), take_i, "R3", "insert acceptance");
      check_now(longint'(ins_tag), it*QD + m_wp[it], "R2", "insert tag");
    end
    @(posedge clk);
    #1;
    if (dv) begin
      m_rdy[dt][ds] = 1;
      m_sq[dt][ds] = m_sq[dt][ds] | dq;
    end
    if (take_r) begin
      m_rp[rt] = (m_rp[rt] + 1) % QD;
      m_cnt[rt]--; m_tot--;
    end
    if (take_i) begin
      m_seq[it][m_wp[it]] = iseq; m_pc[it][m_wp[it]] = ipc;
      m_rdy[it][m_wp[it]] = 0; m_sq[it][m_wp[it]] = 0;
      m_wp[it] = (m_wp[it] + 1) % QD;
      m_cnt[it]++; m_tot++;
    end
    push_all();
  endtask

  task automatic ins(input int t, input int s);
    cyc(1, t, s, 32'h1000 + s*4, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic mark(input int t, input int slot, input bit sq);
    cyc(0, 0, 0, 0, 1, t, slot, sq, 0, 0);
  endtask
  task automatic ret(input int t);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, t);
  endtask
  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lfsr;
    int nseq;
    rst_n = 0; act_mask = 4'hF;
    ins_vld = 0; ins_tid = 0; ins_seq = 0; ins_pc = 0;
    done_vld = 0; done_tag = 0; done_sq = 0; ret_vld = 0; ret_tid = 0;
    for (int t = 0; t < NT; t++) begin m_rp[t] = 0; m_wp[t] = 0; m_cnt[t] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1;
    expect_val(6, 0, 0, "R1"); expect_val(7, 0, 0, "R1");
    expect_val(10, 0, 0, "R1"); expect_val(5, 0, 0, "R1");
    expect_val(0, 0, 0, "R1");

    // Basic inserts across threads
    ins(0, 10); ins(1, 11); ins(0, 12); ins(2, 13);
    expect_val(8, 0, 0, "R7"); expect_val(12, 0, 13, "R8");
    mark(0, 0, 0);
    expect_val(5, 0, 1, "R9");
    ret(1);                                   // head of thread 1 not ready
    expect_val(6, 0, 4, "R5");
    ret(0);
    expect_val(6, 0, 3, "R5"); expect_val(8, 0, 1, "R7");
    act = 4'b1101; idle();
    expect_val(8, 0, 0, "R7"); expect_val(9, 0, 12, "R7");
    mark(1, 0, 0);                            // ready head in disabled thread
    expect_val(5, 0, 0, "R9");
    act = 4'hF; idle();
    expect_val(5, 0, 1, "R9");

    // Thread full, then shared capacity
    ins(3, 20); ins(3, 21); ins(3, 22); ins(3, 23);
    expect_val(11, 0, 3, "R8");
    ins(3, 24);                               // thread 3 full
    expect_val(6, 0, 7, "R3");
    ins(2, 25);
    expect_val(6, 0, 8, "R3");
    ins(0, 26);                               // shared capacity reached
    expect_val(6, 0, 8, "R3");
    mark(3, 0, 1);
    expect_val(4, 3, 1, "R4"); expect_val(3, 3, 1, "R4");

    // Free space and exercise same-cycle insert/retire with wrap
    ret(1); ret(3);
    expect_val(6, 0, 6, "R5");
    mark(3, 1, 0);
    cyc(1, 3, 27, 32'h2000, 0, 0, 0, 0, 1, 3);
    expect_val(6, 0, 6, "R10"); expect_val(1, 3, 22, "R10");
    expect_val(12, 0, 27, "R10");
    ret(0); ret(2);                           // not-ready heads: ignored
    expect_val(6, 0, 6, "R5");

    // Pseudo-random traffic
    lfsr = 32'h1ACE5; nseq = 100;
    for (int n = 0; n < 400; n++) begin
      bit iv, dv, rv;
      int it, dt, ds, rt;
      lfsr = (lfsr << 1) ^ (((lfsr >> 31) ^ (lfsr >> 21) ^ (lfsr >> 1) ^ lfsr) & 1);
      if (n % 16 == 0) act = 4'((lfsr >> 7) & 15);
      iv = ((lfsr >> 3) & 3) != 0;
      it = (lfsr >> 5) & 3;
      rv = ((lfsr >> 9) & 1) != 0;
      rt = (lfsr >> 11) & 3;
      dt = (lfsr >> 13) & 3;
      dv = (m_cnt[dt] > 0) && (((lfsr >> 15) & 1) != 0);
      ds = dv ? (m_rp[dt] + ((lfsr >> 17) % m_cnt[dt])) % QD : 0;
      cyc(iv, it, nseq, (lfsr & 32'h0FFF_FFFC), dv, dt, ds, ((lfsr >> 20) & 7) == 0, rv, rt);
      if (iv) nseq++;
    end
    idle();
    @(posedge clk); #5;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule